// File: doc/BRIEF.md
# Bitstream Binarized Neuron

This block computes one neuron of a binarized network whose arithmetic is carried out on bitstreams. Each of the LANES inputs and each weight is a single bit in bipolar form. A set bit stands for +1 and a clear bit stands for -1. A host pulses `start` with the stream length on `stream_len`. On each of the following `stream_len` clock edges it presents one bit per lane on `in_bits` and `wt_bits`.

Every lane's product is an XNOR of its input bit and its weight bit. On each sampled edge a signed up/down counter moves up by the number of product ones and down by the number of product zeros. The binary activation is taken from the sign bit of the counter's final value as the last sample is added. No threshold subtraction or separate activation stage is used. The result appears on `act` together with a one-cycle `act_valid` pulse, and `act` keeps that value until the next result.

Top module: `bsn_neuron`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `act`, `act_valid` and `busy` are all 0.
- R2: The product of a lane is logic 1 when its input bit equals its weight bit and logic 0 otherwise, with 1 meaning +1 and 0 meaning -1. An input of all zeros against weights of all zeros therefore counts as all +1 products.
- R3: On each sampled edge the running sum grows by (product ones) minus (product zeros) over all lanes. This holds up to a stream of 2^LEN_W-1 samples with every lane agreeing or every lane disagreeing.
- R4: The edge that sees `start` high only arms the block. Samples are taken on exactly the `stream_len` edges after it. `busy` is 1 in each of those cycles, and lane bits outside that window have no effect.
- R5: `act` is 1 when the final sum is zero or positive and 0 when it is negative, so an exact tie gives 1.
- R6: `act_valid` is high for one cycle, in the cycle after the last sample edge, and `busy` is 0 in that cycle.
- R7: A `start` while `busy` abandons the running stream without a result, clears the sum and begins a new stream with the newly presented length.
- R8: A `start` with `stream_len` of 0 gives `act_valid` = 1 and `act` = 1 in the next cycle, and `busy` stays 0.
- R9: `act` changes only in a cycle where `act_valid` is 1, and it holds between results.
- R10: The length is captured at `start`. Changing `stream_len` during the stream does not move the end of the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms a new stream; aborts a running one |
| stream_len | input | LEN_W | Number of samples in the stream, read at `start` |
| in_bits | input | LANES | One bipolar input bit per lane |
| wt_bits | input | LANES | One bipolar weight bit per lane |
| act | output | 1 | Binary activation, 1 for a non-negative sum |
| act_valid | output | 1 | One-cycle pulse when `act` is updated |
| busy | output | 1 | High while samples are being taken |

## Verification
The assertions assume that `start` and the lane bits are free to change on any cycle. They also assume that a result can only come from a completed stream or from an empty one. The stepping check relies on the counter never wrapping, so stimulus stays within lengths of 2^LEN_W-1 at most. It reaches that bound once with every lane agreeing and once with every lane disagreeing. Aborts, length changes in mid-stream and zero-length starts are driven on purpose, and a behavioural model tracks every cycle in each case.

// File: rtl/bsn_pkg.sv
package bsn_pkg;

   // Phase of the stream controller
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_RUN  = 1'b1
   } phase_t;

   // Width of a lane-count value
   function automatic int count_bits(input int lanes);
      return $clog2(lanes + 1);
   endfunction

   // Signed width that holds +/- lanes * (2^len_bits - 1)
   function automatic int acc_bits(input int lanes, input int len_bits);
      return len_bits + $clog2(lanes + 1) + 1;
   endfunction

endpackage

// File: rtl/bsn_lane_products.sv
module bsn_lane_products #(
   parameter int LANES    = 8,
   parameter bit POP_TREE = 1'b1,
   parameter int CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] x_bits,
   input  logic [LANES-1:0] w_bits,
   output logic [CNT_W-1:0] ones
);

   logic [LANES-1:0] prod;

   // Bipolar multiply: equal bits give +1 (logic 1)
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign prod[i] = ~(x_bits[i] ^ w_bits[i]);
   end

   if (POP_TREE && (LANES > 1)) begin : g_tree
      localparam int LVLS   = $clog2(LANES);
      localparam int LEAVES = 1 << LVLS;
      for (genvar lv = 0; lv <= LVLS; lv++) begin : g_lvl
         localparam int NODES = LEAVES >> lv;
         logic [CNT_W-1:0] s [NODES];
         for (genvar n = 0; n < NODES; n++) begin : g_node
            if (lv == 0) begin : g_leaf
               if (n < LANES) begin : g_in
                  assign s[n] = CNT_W'(prod[n]);
               end else begin : g_pad
                  assign s[n] = '0;
               end
            end else begin : g_add
               assign s[n] = g_lvl[lv-1].s[2*n] + g_lvl[lv-1].s[2*n+1];
            end
         end
      end
      assign ones = g_lvl[LVLS].s[0];
   end else begin : g_chain
      always_comb begin
         ones = '0;
         for (int i = 0; i < LANES; i++) begin
            ones = ones + CNT_W'(prod[i]);
         end
      end
   end

   AST_ONES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ones <= CNT_W'(LANES)); // R2

endmodule

// File: rtl/bsn_updown_acc.sv
module bsn_updown_acc #(
   parameter int LANES = 8,
   parameter int CNT_W = 4,
   parameter int ACC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [CNT_W-1:0] ones,
   output logic             nonneg_nxt
);

   logic        [ACC_W-1:0] twice;
   logic signed [ACC_W-1:0] step;
   logic signed [ACC_W-1:0] acc_nxt;
   logic signed [ACC_W-1:0] acc_q;

   // ones - zeros = 2*ones - LANES
   assign twice   = ACC_W'(ones) << 1;
   assign step    = $signed(twice) - $signed(ACC_W'(LANES));
   assign acc_nxt = acc_q + step;

   // Majority mask: the sign bit alone decides, zero counts as majority
   assign nonneg_nxt = ~acc_nxt[ACC_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (clr) begin
         acc_q <= '0;
      end else if (en) begin
         acc_q <= acc_nxt;
      end
   end

   AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0)); // R7
   AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !clr) |=> (((acc_q - $past(acc_q)) <= LANES) && ((acc_q - $past(acc_q)) >= -LANES))); // R3
   AST_ACC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(acc_q)); // R4

endmodule

// File: rtl/bsn_stream_ctrl.sv
module bsn_stream_ctrl #(
   parameter int LEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len,
   output logic             clr,
   output logic             en,
   output logic             last,
   output logic             empty,
   output logic             busy
);
   import bsn_pkg::*;

   phase_t           ph_q;
   logic [LEN_W-1:0] rem_q;

   assign busy  = (ph_q == PH_RUN);
   assign clr   = start;
   assign en    = busy & ~start;
   assign last  = en & (rem_q == LEN_W'(1));
   assign empty = start & (len == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         rem_q <= '0;
      end else if (start) begin
         ph_q  <= (len == '0) ? PH_IDLE : PH_RUN;
         rem_q <= len;
      end else if (en) begin
         rem_q <= rem_q - LEN_W'(1);
         if (last) begin
            ph_q <= PH_IDLE;
         end
      end
   end

   AST_RUN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (len != '0)) |=> busy); // R4
   AST_REM_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && (rem_q > LEN_W'(1))) |=> (busy && (rem_q == $past(rem_q) - LEN_W'(1)))); // R10
   AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !start && (rem_q == LEN_W'(1))) |=> !busy); // R4

endmodule

// File: rtl/bsn_neuron.sv
module bsn_neuron #(
   parameter int LANES    = 8,
   parameter int LEN_W    = 11,
   parameter bit POP_TREE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] stream_len,
   input  logic [LANES-1:0] in_bits,
   input  logic [LANES-1:0] wt_bits,
   output logic             act,
   output logic             act_valid,
   output logic             busy
);

   localparam int CNT_W = bsn_pkg::count_bits(LANES);
   localparam int ACC_W = bsn_pkg::acc_bits(LANES, LEN_W);

   if (LANES < 1) begin : g_bad_lanes
      $error("bsn_neuron: LANES must be at least 1");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("bsn_neuron: LEN_W must be at least 1");
   end
   if (ACC_W > 62) begin : g_bad_acc
      $error("bsn_neuron: accumulator wider than supported");
   end

   logic             clr, en, last, empty;
   logic [CNT_W-1:0] ones;
   logic             nonneg_nxt;
   logic             act_q, valid_q;

   bsn_stream_ctrl #(.LEN_W(LEN_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .len   (stream_len),
      .clr   (clr),
      .en    (en),
      .last  (last),
      .empty (empty),
      .busy  (busy)
   );

   bsn_lane_products #(.LANES(LANES), .POP_TREE(POP_TREE), .CNT_W(CNT_W)) u_prod (
      .clk    (clk),
      .rst_n  (rst_n),
      .x_bits (in_bits),
      .w_bits (wt_bits),
      .ones   (ones)
   );

   bsn_updown_acc #(.LANES(LANES), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_acc (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (clr),
      .en         (en),
      .ones       (ones),
      .nonneg_nxt (nonneg_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= empty | last;
         if (empty) begin
            act_q <= 1'b1;
         end else if (last) begin
            act_q <= nonneg_nxt;
         end
      end
   end

   assign act       = act_q;
   assign act_valid = valid_q;

   AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |-> !busy); // R6
   AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act) |-> act_valid); // R9
   AST_EMPTY_TIE: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (stream_len == '0)) |=> (act_valid && act && !busy)); // R8

endmodule

// File: tb/tb_bsn_neuron.sv
module tb_bsn_neuron;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int LANES = 8;
   localparam int LEN_W = 11;
   localparam int MAXN  = (1 << LEN_W) - 1;
   localparam logic [LANES-1:0] LOW_HALF  = LANES'((1 << (LANES/2)) - 1);
   localparam logic [LANES-1:0] FIVE_OFF  = LANES'(5'h1F);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start = 1'b0;
   logic [LEN_W-1:0] stream_len = '0;
   logic [LANES-1:0] in_bits = '0;
   logic [LANES-1:0] wt_bits = '0;
   logic             act, act_valid, busy;

   int n_tests = 0;
   int n_fail  = 0;
   int n_valid = 0;
   bit finished = 1'b0;

   // reference model state
   int m_acc = 0;
   int m_rem = 0;
   bit m_busy = 1'b0;
   bit m_valid = 1'b0;
   bit m_act = 1'b0;

   always #5 clk = ~clk;

   bsn_neuron #(.LANES(LANES), .LEN_W(LEN_W)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .stream_len (stream_len),
      .in_bits    (in_bits),
      .wt_bits    (wt_bits),
      .act        (act),
      .act_valid  (act_valid),
      .busy       (busy)
   );

   task automatic chk(input string tag, input logic got, input logic exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
      end
   endtask

   // behavioural reference, one step per clock edge
   always @(posedge clk) begin
      if (act_valid) n_valid++;
      if (!rst_n) begin
         m_acc = 0; m_rem = 0; m_busy = 0; m_valid = 0; m_act = 0;
      end else begin
         m_valid = 0;
         if (start) begin
            m_acc = 0;
            m_rem = int'(stream_len);
            if (stream_len == 0) begin
               m_busy = 0; m_valid = 1; m_act = 1;
            end else begin
               m_busy = 1;
            end
         end else if (m_busy) begin
            for (int i = 0; i < LANES; i++) begin
               if (in_bits[i] == wt_bits[i]) m_acc = m_acc + 1;
               else m_acc = m_acc - 1;
            end
            m_rem = m_rem - 1;
            if (m_rem == 0) begin
               m_busy = 0; m_valid = 1; m_act = (m_acc >= 0);
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R4 model busy", busy, m_busy);
         chk("R6 model act_valid", act_valid, m_valid);
         chk("R5 model act", act, m_act);
      end
   end

   task automatic drive(input int kind, input int idx);
      logic [LANES-1:0] r;
      r = LANES'($urandom);
      case (kind)
         0: begin in_bits = '0; wt_bits = '0; end
         1: begin in_bits = r; wt_bits = ~r; end
         2: begin in_bits = r; wt_bits = r ^ LOW_HALF; end
         3: begin in_bits = r; wt_bits = r ^ FIVE_OFF; end
         5: begin in_bits = r; wt_bits = (idx == 0) ? r : (r ^ FIVE_OFF); end
         default: begin in_bits = r; wt_bits = LANES'($urandom); end
      endcase
   endtask

   // start, n sample cycles, then check the result cycle
   task automatic stream(input int n, input int alt_n, input int kind,
                         input int exp_act, input string tag);
      @(negedge clk);
      start = 1'b1;
      stream_len = LEN_W'(n);
      in_bits = LANES'($urandom);
      wt_bits = LANES'($urandom);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         start = 1'b0;
         stream_len = LEN_W'(alt_n);
         chk({tag, " busy in window"}, busy, 1'b1);
         drive(kind, i);
      end
      @(negedge clk);
      start = 1'b0;
      chk({tag, " valid"}, act_valid, 1'b1);
      chk({tag, " idle at result"}, busy, 1'b0);
      if (exp_act >= 0) chk({tag, " act"}, act, exp_act[0]);
      stream_len = LEN_W'(n);
   endtask

   initial begin
      int v0;
      logic held;
      repeat (3) @(negedge clk);
      chk("R1 act in reset", act, 1'b0);
      chk("R1 valid in reset", act_valid, 1'b0);
      chk("R1 busy in reset", busy, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 act after reset", act, 1'b0);
      chk("R1 valid after reset", act_valid, 1'b0);

      stream(16, 16, 0, 1, "R2 zeros against zeros");
      stream(16, 16, 1, 0, "R2 all lanes disagree");
      stream(10, 10, 2, 1, "R5 exact tie");
      stream(1, 1, 3, 0, "R5 sum of -2");
      stream(5, 5, 5, 1, "R3 +8 then -8 gives tie");
      stream(6, 6, 5, 0, "R3 +8 then -10");
      stream(MAXN, MAXN, 0, 1, "R3 max length agree");
      stream(MAXN, MAXN, 1, 0, "R3 max length disagree");

      // R8: empty stream
      @(negedge clk);
      start = 1'b1; stream_len = '0;
      @(negedge clk);
      start = 1'b0; stream_len = LEN_W'(3);
      chk("R8 valid", act_valid, 1'b1);
      chk("R8 act", act, 1'b1);
      chk("R8 busy", busy, 1'b0);

      // R7: abort a stream that was heading negative
      @(negedge clk);
      v0 = n_valid;
      start = 1'b1; stream_len = LEN_W'(20);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         start = 1'b0;
         drive(1, i);
      end
      stream(4, 4, 0, 1, "R7 restart");
      @(negedge clk);
      chk("R7 single result", (n_valid == v0 + 1), 1'b1);

      // R10: length change during the stream
      stream(6, 1, 4, -1, "R10 length captured");
      stream(3, 0, 4, -1, "R10 length cleared mid-stream");

      // R9: act holds while inputs move without start
      stream(7, 7, 0, 1, "R9 set");
      held = act;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         drive(4, i);
         chk("R9 act held", act, held);
         chk("R4 idle ignores lanes", busy, 1'b0);
      end

      for (int k = 0; k < 25; k++) begin
         int n;
         n = 1 + int'($urandom % 40);
         stream(n, n, 4, -1, "R3 random");
      end

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #1500000;
      if (!finished) begin
         finished = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule